// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Sequencer

This block sits between a synchronous request interface and an external asynchronous static RAM that is 16 bits wide and 64K words deep. The memory has active-low chip select, write enable and output enable, plus one active-low enable per byte lane. A client presents one request at a time: a word address, a read/write flag, write data and a byte-lane mask. When an access finishes, the block raises a one-cycle completion pulse. For reads, the returned word comes with that pulse.

The memory needs no clock, so every timing rule is a count of clock cycles. The rules are the write strobe width, data setup before the end of write, access time from the output strobe, and the time the memory needs to release the bus. Each count is derived at elaboration from nanosecond-class parameters (in picoseconds) and the clock period, always rounded up.

All memory strobes leave the block straight from flip-flops. The shared data bus is presented as separate drive value, drive enable and sampled input signals, so the tristate buffer can be placed at chip level.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, `req_ready` is 1, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, both bits of `mem_lane_n` are 1, `mem_dq_oe` is 0 and `rsp_done` is 0; an asynchronous reset during an access returns these outputs to that state at once.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1; `req_ready` stays 0 until the access ends, and `req_valid` pulses while busy start no access and change no memory word.
- R3: A read keeps `mem_cs_n` low from its first cycle and `mem_we_n` high throughout; `mem_oe_n` is low for exactly ceil(max(T_ACC, T_OE_ACC) / T_CLK) consecutive cycles (2 with the defaults), starting in the second cycle of the access.
- R4: Read data is sampled at the clock edge that ends the output-enable window and appears on `rsp_rdata` together with a one-cycle `rsp_done` pulse; lane i (bits 8i+7..8i) is returned only if `req_mask[i]` is 1, otherwise it reads as zero.
- R5: A write drives `mem_dq_oe` = 1 and `mem_dq_out` = the write data from its first cycle through the cycle after `mem_we_n` rises; `mem_we_n` is low for exactly ceil(T_WP / T_CLK) cycles (1 with the defaults), always with `mem_cs_n` low; `rsp_done` pulses in the release cycle.
- R6: `mem_lane_n` equals the bitwise inverse of the request mask (bit 0 for data bits 7..0, bit 1 for bits 15..8) during the whole access, so a partial write alters only the selected lanes and a write with mask 00 leaves the word unchanged.
- R7: `mem_addr` and `mem_lane_n` hold their values on every cycle that `mem_cs_n` is low, including the cycle after a strobe is released.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and it rises only after `mem_oe_n` has been high for more than ceil(T_BUS_REL / T_CLK) cycles.
- R9: With the defaults, counted in clock edges after the edge that takes the request, a read raises `rsp_done` in cycle 4 and `req_ready` in cycle 6, and a write raises `rsp_done` in cycle 3 and `req_ready` in cycle 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte-lane select, bit i enables bits 8i+7..8i |
| req_ready | output | 1 | Idle, a request is taken this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done after a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_dq_out | output | DATA_W | Value to drive onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus buffer |
| mem_dq_in | input | DATA_W | Value sampled from the data bus |

## Verification
Assertions check several rules on every cycle. The bus drive is never enabled while the memory's outputs are enabled, and it is never enabled again until the release window has passed. The write strobe only goes low inside a selected, driven access. Address and lane enables hold while the chip is selected. The strobe pulse widths reach their derived counts, and the completion pulse lasts one cycle. Only the bench's scenarios can show that data actually round-trips through the memory, that partial and empty masks merge lanes correctly, the exact latency of each access kind, and that requests offered while busy or cut off by reset leave the memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_SETUP    = 3'd1,
      ST_RD_WAIT  = 3'd2,
      ST_RD_CAPT  = 3'd3,
      ST_WR_PULSE = 3'd4,
      ST_WR_REL   = 3'd5,
      ST_TURN     = 3'd6
   } seq_state_t;

   // Whole clock cycles needed to cover a delay, rounded up.
   function automatic int cycles_for(input int delay_ps, input int clk_ps);
      return (delay_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int RD_CYC   = 2,
   parameter int WP_CYC   = 1,
   parameter int TURN_CYC = 1,
   parameter int CNT_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             op_write,
   input  logic             tmr_expired,
   output seq_state_t       state_q,
   output seq_state_t       state_nxt,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val
);

   localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

   always_comb begin
      state_nxt = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) state_nxt = ST_SETUP;
         end
         ST_SETUP: begin
            tmr_load = 1'b1;
            if (op_write) begin
               state_nxt = ST_WR_PULSE;
               tmr_val   = WP_LOAD;
            end else begin
               state_nxt = ST_RD_WAIT;
               tmr_val   = RD_LOAD;
            end
         end
         ST_RD_WAIT: begin
            if (tmr_expired) state_nxt = ST_RD_CAPT;
         end
         ST_RD_CAPT: begin
            state_nxt = ST_TURN;
            tmr_load  = 1'b1;
            tmr_val   = TURN_LOAD;
         end
         ST_TURN: begin
            if (tmr_expired) state_nxt = ST_IDLE;
         end
         ST_WR_PULSE: begin
            if (tmr_expired) state_nxt = ST_WR_REL;
         end
         ST_WR_REL: begin
            state_nxt = ST_IDLE;
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_nxt;
   end

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    capture,
   input  logic [LANES-1:0]        lane_en,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] rdata
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata[l*LANE_W +: LANE_W] <= '0;
         end else if (capture) begin
            rdata[l*LANE_W +: LANE_W] <= lane_en[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
         end
      end
   end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int CLK_PS      = 10000,
   parameter int ACC_PS      = 12000,
   parameter int OE_ACC_PS   = 7000,
   parameter int WP_PS       = 9000,
   parameter int DSETUP_PS   = 7000,
   parameter int BUS_REL_PS  = 6000,
   parameter int MIN_CYC_PS  = 12000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_mask,
   output logic                  req_ready,
   output logic                  rsp_done,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic                  mem_cs_n,
   output logic                  mem_we_n,
   output logic                  mem_oe_n,
   output logic [DATA_W/8-1:0]   mem_lane_n,
   output logic [DATA_W-1:0]     mem_dq_out,
   output logic                  mem_dq_oe,
   input  logic [DATA_W-1:0]     mem_dq_in
);

   localparam int LANE_W   = 8;
   localparam int LANES    = DATA_W / LANE_W;
   localparam int RD_CYC   = max3(cycles_for(ACC_PS, CLK_PS),
                                  cycles_for(OE_ACC_PS, CLK_PS), 1);
   localparam int WP_CYC   = max3(cycles_for(WP_PS, CLK_PS), 1, 1);
   localparam int TURN_CYC = max3(cycles_for(BUS_REL_PS, CLK_PS), 1, 1);
   localparam int CNT_MAX  = max3(RD_CYC, WP_CYC, TURN_CYC);
   localparam int CNT_W    = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

   // Elaboration-time configuration checks
   initial begin : cfg_chk
      assert (DATA_W >= LANE_W && DATA_W % LANE_W == 0)
         else $error("DATA_W must be a multiple of %0d", LANE_W);
      assert (ADDR_W >= 1) else $error("ADDR_W must be positive");
      assert (CLK_PS > 0) else $error("CLK_PS must be positive");
      assert ((WP_CYC + 1) * CLK_PS >= DSETUP_PS)
         else $error("write data setup not covered");
      assert ((WP_CYC + 2) * CLK_PS >= MIN_CYC_PS)
         else $error("write cycle shorter than minimum");
      assert ((RD_CYC + 3) * CLK_PS >= MIN_CYC_PS)
         else $error("read cycle shorter than minimum");
      assert (TURN_CYC < 200) else $error("turnaround count too large");
   end

   // ---------------------------------------------------------------
   // Request capture
   // ---------------------------------------------------------------
   seq_state_t        state_q, state_nxt;
   logic              accept;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else if (accept) begin
         wr_q    <= req_write;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         mask_q  <= req_mask;
      end
   end

   // ---------------------------------------------------------------
   // Sequencer and wait timer
   // ---------------------------------------------------------------
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;

   sram_seq_fsm #(
      .RD_CYC   (RD_CYC),
      .WP_CYC   (WP_CYC),
      .TURN_CYC (TURN_CYC),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .op_write    (wr_q),
      .tmr_expired (tmr_expired),
      .state_q     (state_q),
      .state_nxt   (state_nxt),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val)
   );

   sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   // ---------------------------------------------------------------
   // Strobes, registered from the next state so no decode glitch
   // reaches the memory pins.
   // ---------------------------------------------------------------
   logic             sel_nxt, drive_nxt, wr_nxt;
   logic [LANES-1:0] mask_nxt;

   assign wr_nxt   = accept ? req_write : wr_q;
   assign mask_nxt = accept ? req_mask  : mask_q;

   always_comb begin
      sel_nxt   = 1'b0;
      drive_nxt = 1'b0;
      unique case (state_nxt)
         ST_SETUP:    begin sel_nxt = 1'b1; drive_nxt = wr_nxt; end
         ST_RD_WAIT,
         ST_RD_CAPT:  sel_nxt = 1'b1;
         ST_WR_PULSE,
         ST_WR_REL:   begin sel_nxt = 1'b1; drive_nxt = 1'b1; end
         default:     ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_cs_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_lane_n <= '1;
         mem_dq_oe  <= 1'b0;
         rsp_done   <= 1'b0;
      end else begin
         mem_cs_n   <= !sel_nxt;
         mem_we_n   <= !(state_nxt == ST_WR_PULSE);
         mem_oe_n   <= !(state_nxt == ST_RD_WAIT);
         mem_lane_n <= sel_nxt ? ~mask_nxt : '1;
         mem_dq_oe  <= drive_nxt;
         rsp_done   <= (state_nxt == ST_RD_CAPT) || (state_nxt == ST_WR_REL);
      end
   end

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;

   // ---------------------------------------------------------------
   // Read data capture, one register per lane
   // ---------------------------------------------------------------
   logic capture;
   assign capture = (state_q == ST_RD_WAIT) && (state_nxt == ST_RD_CAPT);

   sram_lane_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .lane_en (mask_q),
      .dq_in   (mem_dq_in),
      .rdata   (rsp_rdata)
   );

   // ---------------------------------------------------------------
   // Protocol checks
   // ---------------------------------------------------------------
   logic [7:0] we_lo_cnt, oe_lo_cnt, oe_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         oe_lo_cnt <= '0;
         oe_hi_cnt <= 8'hFF;
      end else begin
         we_lo_cnt <= mem_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
         oe_lo_cnt <= mem_oe_n ? 8'd0 : ((oe_lo_cnt == 8'hFF) ? oe_lo_cnt : oe_lo_cnt + 8'd1);
         oe_hi_cnt <= !mem_oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_lane_n)));

   // R3
   rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_lo_cnt == 8'(RD_CYC)));

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R5
   we_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_dq_oe && mem_oe_n));

   // R5
   wp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt == 8'(WP_CYC)));

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_lane_n)));

   // R8
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n));

   // R8
   bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (oe_hi_cnt > 8'(TURN_CYC)));

endmodule

// File: tb/tb_sram_bus_ctrl.sv
module tb_sram_bus_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        req_ready, rsp_done;
   logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
   logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0]  mem_lane_n;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   sram_bus_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_mask(req_mask),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // Simple memory model: read when selected, enabled and not writing;
   // write committed per lane when the write strobe rises.
   logic [15:0] model_mem [logic [15:0]];

   function automatic logic [15:0] peek(input logic [15:0] a);
      return model_mem.exists(a) ? model_mem[a] : 16'h0000;
   endfunction

   always @(*) begin
      mem_dq_in = 16'h0000;
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
         if (!mem_lane_n[0]) mem_dq_in[7:0]  = peek(mem_addr) >> 0;
         if (!mem_lane_n[1]) mem_dq_in[15:8] = peek(mem_addr) >> 8;
      end
   end

   always @(posedge mem_we_n) begin
      if (rst_n && !mem_cs_n && mem_dq_oe) begin
         logic [15:0] w;
         w = peek(mem_addr);
         if (!mem_lane_n[0]) w[7:0]  = mem_dq_out[7:0];
         if (!mem_lane_n[1]) w[15:8] = mem_dq_out[15:8];
         model_mem[mem_addr] = w;
      end
   end

   // Bus monitor for R8
   int  conflicts = 0;
   int  short_turns = 0;
   int  oe_hi_run = 100;
   logic dq_oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe && !mem_oe_n) conflicts++;
         if (mem_dq_oe && !dq_oe_prev && oe_hi_run < 2) short_turns++;
         oe_hi_run  = !mem_oe_n ? 0 : ((oe_hi_run < 100) ? oe_hi_run + 1 : oe_hi_run);
         dq_oe_prev = mem_dq_oe;
      end else begin
         oe_hi_run  = 100;
         dq_oe_prev = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One access; inject=1 offers a write request while busy (R2).
   task automatic do_access(input logic wr, input logic [15:0] a, input logic [1:0] m,
                            input logic [15:0] wd, input logic [15:0] exp, input bit inject);
      int n, done_at, ready_at, oe_lo, we_lo, drift;
      @(negedge clk);
      chk(req_ready == 1'b1, "R2", "ready before request", 32'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      // First cycle of the access
      chk(mem_cs_n == 1'b0, "R3", "select in first cycle", 32'(mem_cs_n), 0);
      chk(mem_lane_n == ~m, "R6", "lane enables", 32'(mem_lane_n), 32'(~m));
      chk(mem_addr == a, "R7", "address", 32'(mem_addr), 32'(a));
      chk(mem_dq_oe == wr, "R5", "drive in first cycle", 32'(mem_dq_oe), 32'(wr));
      chk(req_ready == 1'b0, "R2", "busy after accept", 32'(req_ready), 0);
      done_at = 0; ready_at = 0; oe_lo = 0; we_lo = 0; drift = 0;
      while (n < 20 && ready_at == 0) begin
         if (inject) begin
            req_valid = (n == 2 || n == 3);
            req_write = 1'b1; req_wdata = 16'hFFFF;
         end
         if (!mem_oe_n) oe_lo++;
         if (!mem_we_n) we_lo++;
         if (mem_dq_oe && mem_dq_out != wd) drift++;
         if (!mem_cs_n && (mem_addr != a || mem_lane_n != ~m)) drift++;
         if (rsp_done) begin
            chk(done_at == 0, "R4", "single done pulse", 32'(done_at), 0);
            done_at = n;
            if (!wr) chk(rsp_rdata == exp, "R4", "read data", 32'(rsp_rdata), 32'(exp));
         end
         if (req_ready) ready_at = n;
         else begin
            @(negedge clk);
            n++;
         end
      end
      req_valid = 1'b0;
      chk(drift == 0, "R7", "address/lane/data held", 32'(drift), 0);
      chk(done_at == (wr ? 3 : 4), "R9", "done cycle", 32'(done_at), wr ? 3 : 4);
      chk(ready_at == (wr ? 4 : 6), "R9", "ready cycle", 32'(ready_at), wr ? 4 : 6);
      chk(oe_lo == (wr ? 0 : 2), "R3", "output enable cycles", 32'(oe_lo), wr ? 0 : 2);
      chk(we_lo == (wr ? 1 : 0), "R5", "write strobe cycles", 32'(we_lo), wr ? 1 : 0);
   endtask

   // Vector fields: {write, addr, mask, wdata, expected read data}
   localparam int NV = 13;
   localparam logic [50:0] VECS [NV] = '{
      {1'b1, 16'h0010, 2'b11, 16'hA5C3, 16'h0000},
      {1'b0, 16'h0010, 2'b11, 16'h0000, 16'hA5C3},
      {1'b1, 16'h0010, 2'b01, 16'h1177, 16'h0000},
      {1'b0, 16'h0010, 2'b11, 16'h0000, 16'hA577},
      {1'b1, 16'h0010, 2'b10, 16'h88EE, 16'h0000},
      {1'b0, 16'h0010, 2'b01, 16'h0000, 16'h0077},
      {1'b0, 16'h0010, 2'b10, 16'h0000, 16'h8800},
      {1'b1, 16'hFFFF, 2'b11, 16'h5A5A, 16'h0000},
      {1'b0, 16'hFFFF, 2'b11, 16'h0000, 16'h5A5A},
      {1'b0, 16'h0010, 2'b00, 16'h0000, 16'h0000},
      {1'b1, 16'hFFFF, 2'b00, 16'h0000, 16'h0000},
      {1'b0, 16'hFFFF, 2'b11, 16'h0000, 16'h5A5A},
      {1'b0, 16'h0000, 2'b11, 16'h0000, 16'h0000}
   };

   bit finished = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 1);
      chk({mem_cs_n, mem_we_n, mem_oe_n} == 3'b111, "R1", "strobes in reset",
          32'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
      chk(mem_lane_n == 2'b11 && !mem_dq_oe && !rsp_done, "R1", "lanes/drive/done in reset",
          32'({mem_lane_n, mem_dq_oe, rsp_done}), 32'h c);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(mem_cs_n && !mem_dq_oe, "R1", "idle after reset", 32'({mem_cs_n, mem_dq_oe}), 2);

      // Vector table (R4, R6 partial lanes and empty mask)
      for (int i = 0; i < NV; i++) begin
         do_access(VECS[i][50], VECS[i][49:34], VECS[i][33:32],
                   VECS[i][31:16], VECS[i][15:0], 1'b0);
      end

      // R2: requests offered while busy are ignored
      do_access(1'b0, 16'h0010, 2'b11, 16'h0000, 16'h8877, 1'b1);
      do_access(1'b0, 16'h0010, 2'b11, 16'h0000, 16'h8877, 1'b0);

      // R8: read followed directly by write
      do_access(1'b0, 16'hFFFF, 2'b11, 16'h0000, 16'h5A5A, 1'b0);
      do_access(1'b1, 16'h0040, 2'b11, 16'hC0DE, 16'h0000, 1'b0);
      do_access(1'b0, 16'h0040, 2'b11, 16'h0000, 16'hC0DE, 1'b0);
      chk(conflicts == 0, "R8", "drive while output enabled", 32'(conflicts), 0);
      chk(short_turns == 0, "R8", "drive before release window", 32'(short_turns), 0);

      // R1: reset in the middle of a write
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0040;
      req_mask = 2'b11; req_wdata = 16'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(mem_we_n == 1'b0, "R5", "strobe low before reset", 32'(mem_we_n), 0);
      rst_n = 1'b0;
      #1;
      chk(req_ready && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && mem_lane_n == 2'b11,
          "R1", "asynchronous reset mid-write",
          32'({req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 32'h1e);
      @(negedge clk);
      rst_n = 1'b1;
      do_access(1'b0, 16'h0040, 2'b11, 16'h0000, 16'hC0DE, 1'b0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule